// File: doc/BRIEF.md
# Full-Duplex PAUSE Timer

This block sits beside a full-duplex Ethernet transmit MAC and turns received flow-control PAUSE requests into a transmit-inhibit signal. A separate receive path decodes PAUSE frames and checks them. It then raises a one-cycle strobe together with the frame's 16-bit pause value. That value is measured in slot-times of 512 bit times each. The block loads the value into a down-counter. The counter steps down once per slot-time tick from the MAC's timing logic. While the count is non-zero, the MAC is told not to begin a new frame.

The block never cuts a frame short. If a PAUSE request lands while a frame is on the wire, a short grace window opens, measured in slot-time ticks. During the window the inhibit stays low. The window ends early if the transmitter goes idle or if one more frame is started. Once it ends, the inhibit follows the pause state. Handling is active only with flow control enabled on a full-duplex link. Otherwise any held pause is dropped at once.

Top module: `pause_timer`

## Requirements
- R1: After reset, `tx_hold` and `pause_active` are both 0.
- R2: A `pause_rx` strobe with a non-zero `pause_quanta` value N, taken while handling is active, makes `pause_active` 1 from the next cycle. `pause_active` then returns to 0 after exactly N further `slot_tick` cycles. Values up to 65535 are accepted.
- R3: A `pause_rx` strobe with `pause_quanta` = 0 clears the count in the next cycle, so that `pause_active` and `tx_hold` are both 0.
- R4: A `pause_rx` strobe that arrives while paused replaces the remaining count with the new value.
- R5: Handling is active only when `fc_enable` = 1 and `full_duplex` = 1. When it is not active, strobes are ignored and the count is cleared on the next clock.
- R6: When `tx_busy` = 0, `tx_hold` equals `pause_active` in the same cycle. `tx_hold` is never 1 while `pause_active` is 0.
- R7: A non-zero PAUSE request taken while `tx_busy` = 1 opens a grace window of GRACE_TICKS slot ticks, default 1. `tx_hold` stays 0 during the window and becomes 1 once the window's ticks have elapsed.
- R8: The grace window is closed early by a cycle with `tx_busy` = 0 or by a `tx_start` pulse. After that, `tx_hold` follows `pause_active` even while a frame is in progress.
- R9: Slot ticks with the count at zero leave it at zero, with no wrap-around.
- R10: When `pause_rx` and `slot_tick` arrive in the same cycle, the load takes priority. The full value N is loaded, and N further ticks are needed to end the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_enable | input | 1 | Flow-control handling enable |
| full_duplex | input | 1 | Link is in full-duplex mode |
| pause_rx | input | 1 | One-cycle strobe: valid PAUSE frame received |
| pause_quanta | input | 16 | Pause time of that frame, in slot-times |
| slot_tick | input | 1 | One-cycle pulse per elapsed slot-time |
| tx_start | input | 1 | Pulse when the MAC begins a frame |
| tx_busy | input | 1 | MAC is sending a frame |
| tx_hold | output | 1 | Do not begin a new frame |
| pause_active | output | 1 | Pause count is non-zero |

## Verification
Pause values 1 through 6 are each loaded and counted down tick by tick. This confirms that the release comes after exactly N ticks and not one tick early or late. A maximum-size value, a mid-pause reload and a zero value are also applied. Together they separate a reload that replaces the count from one that adds to it, and a zero that clears from one that is ignored.

Strobes coinciding with ticks show whether the load wins over the decrement. Each enable/duplex combination is applied to show the gating. Requests landing mid-frame are ended by a tick, by an idle cycle and by a frame start in turn, which tells the three ways out of the grace window apart.

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int QW          = 16,
  parameter int GRACE_TICKS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_enable,
  input  logic          full_duplex,
  input  logic          pause_rx,
  input  logic [QW-1:0] pause_quanta,
  input  logic          slot_tick,
  input  logic          tx_start,
  input  logic          tx_busy,
  output logic          tx_hold,
  output logic          pause_active
);
  localparam int GW = $clog2(GRACE_TICKS + 1);

  logic [QW-1:0] count_q;
  logic [GW-1:0] grace_q;

  wire fc_on = fc_enable & full_duplex;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              count_q <= '0;
    else if (!fc_on)                         count_q <= '0;
    else if (pause_rx)                       count_q <= pause_quanta;
    else if (slot_tick && count_q != '0)     count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              grace_q <= '0;
    else if (!fc_on)                         grace_q <= '0;
    else if (pause_rx)                       grace_q <= (pause_quanta != '0) ? GW'(GRACE_TICKS) : '0;
    else if (!tx_busy || tx_start)           grace_q <= '0;
    else if (slot_tick && grace_q != '0)     grace_q <= grace_q - 1'b1;
  end

  assign pause_active = |count_q;
  assign tx_hold      = pause_active & ((grace_q == '0) | ~tx_busy);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && pause_rx && pause_quanta != '0) |=> pause_active);

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && pause_rx && pause_quanta == '0) |=> (!pause_active && !tx_hold));

  p_gated_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_on |=> !pause_active);

  p_hold_needs_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> pause_active);

  p_grace_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && pause_rx && pause_quanta != '0) |=> (tx_busy |-> !tx_hold));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_active && !(fc_on && pause_rx)) |=> !pause_active);
endmodule

// File: tb/pause_timer_tb.sv
module pause_timer_tb;
  logic clk = 0, rst_n = 0;
  logic fc_enable = 0, full_duplex = 0, pause_rx = 0, slot_tick = 0;
  logic tx_start = 0, tx_busy = 0;
  logic [15:0] pause_quanta = '0;
  logic tx_hold, pause_active;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pause_timer u_dut (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .full_duplex(full_duplex),
    .pause_rx(pause_rx), .pause_quanta(pause_quanta), .slot_tick(slot_tick),
    .tx_start(tx_start), .tx_busy(tx_busy), .tx_hold(tx_hold), .pause_active(pause_active));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic rx, input logic [15:0] q, input logic tk);
    pause_rx = rx; pause_quanta = q; slot_tick = tk;
    @(posedge clk); #1;
    pause_rx = 0; slot_tick = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1 hold", tx_hold, 0); chk("R1 active", pause_active, 0);
    rst_n = 1; fc_enable = 1; full_duplex = 1;
    cyc(0, 0, 0);

    for (int n = 1; n <= 6; n++) begin
      cyc(1, 16'(n), 0);
      chk("R2 active after load", pause_active, 1);
      chk("R6 hold when idle", tx_hold, 1);
      for (int k = 1; k <= n; k++) begin
        cyc(0, 0, 1);
        chk("R2 countdown", pause_active, (n - k) > 0);
        chk("R6 hold follows", tx_hold, (n - k) > 0);
      end
      cyc(0, 0, 1); cyc(0, 0, 1);
      chk("R9 stays zero", pause_active, 0);
    end

    cyc(1, 16'hFFFF, 0);
    repeat (3) cyc(0, 0, 1);
    chk("R2 max value", pause_active, 1);
    cyc(1, 0, 0);
    chk("R3 zero clears active", pause_active, 0);
    chk("R3 zero clears hold", tx_hold, 0);

    cyc(1, 10, 0);
    repeat (3) cyc(0, 0, 1);
    cyc(1, 2, 0);
    cyc(0, 0, 1);
    chk("R4 reload 1 left", pause_active, 1);
    cyc(0, 0, 1);
    chk("R4 reload expired", pause_active, 0);

    cyc(1, 3, 1);
    cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R10 load wins", pause_active, 1);
    cyc(0, 0, 1);
    chk("R10 expires after N", pause_active, 0);

    fc_enable = 0;
    cyc(1, 5, 0);
    chk("R5 fc off ignored", pause_active, 0);
    fc_enable = 1; full_duplex = 0;
    cyc(1, 5, 0);
    chk("R5 half duplex ignored", pause_active, 0);
    chk("R5 half duplex hold", tx_hold, 0);
    full_duplex = 1;
    cyc(1, 5, 0);
    chk("R5 loads when on", pause_active, 1);
    fc_enable = 0;
    cyc(0, 0, 0);
    chk("R5 disable clears", pause_active, 0);
    fc_enable = 1;

    tx_busy = 1;
    cyc(1, 50, 0);
    chk("R7 grace active", pause_active, 1);
    chk("R7 grace hold low", tx_hold, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R7 grace persists", tx_hold, 0);
    cyc(0, 0, 1);
    chk("R7 grace expired", tx_hold, 1);

    cyc(1, 50, 0);
    chk("R7 reload reopens", tx_hold, 0);
    tx_busy = 0; #1;
    chk("R8 idle raises hold", tx_hold, 1);
    cyc(0, 0, 0);
    tx_busy = 1; #1;
    chk("R8 idle closed grace", tx_hold, 1);

    cyc(1, 50, 0);
    chk("R8 grace before start", tx_hold, 0);
    tx_start = 1;
    cyc(0, 0, 0);
    tx_start = 0;
    chk("R8 start closes grace", tx_hold, 1);

    cyc(1, 0, 0);
    chk("R3 clear in frame", tx_hold, 0);
    tx_busy = 0;
    cyc(0, 0, 1);
    chk("R9 final zero", pause_active, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule